// File: doc/BRIEF.md
# Reset Shadow Register Loader

This block keeps four 8-bit non-volatile configuration bytes and copies each one into a volatile shadow register whenever the system reset is released. The shadow registers drive peripheral configuration: a control byte, an oscillator trim byte, a calibration byte and a port-initialisation byte. The copy runs in a fixed sequence, one register per clock. The port-initialisation byte goes first, so that the pins it governs reach their start-up state in the first cycle after reset. `loadDone` rises with the last copy, and peripherals are meant to stay in reset until it is high.

The non-volatile bytes can be changed only through a programming port, only while programming mode is active, and only while the three security bits of the control byte are all clear. They are modelled as flip-flops. These flip-flops are cleared to factory values by a separate power-on reset (`porN`) and keep their contents through the system reset (`rstN`). After loading, the trim shadow accepts software writes from a byte-wide bus at a fixed address, for fine frequency adjustment. Such a write never reaches the non-volatile copy, so the next reset restores the stored trim.

Top module: `init_shadow_loader`

## Requirements
- R1: While `porN` is low the non-volatile bytes take their factory values: control 0x00, trim `FACTORY_TRIM`, calibration `FACTORY_CAL`, port `FACTORY_PORT`. These values appear on the shadows after the next load sequence.
- R2: While `rstN` is low, all four shadow outputs read 0x00 and `loadDone` is 0.
- R3: After `rstN` rises, the load sequence uses one rising clock edge per register. The first edge copies the port byte, the second the control byte, the third the trim byte and the fourth the calibration byte. A shadow that has not yet been copied reads 0x00.
- R4: `loadDone` rises on the same edge as the fourth copy and stays high until the next assertion of `rstN`.
- R5: A programming write (`nvWrEn`, `nvWrSel` code 0=control, 1=trim, 2=calibration, 3=port) updates the selected non-volatile byte only when `progMode` is 1 and control bits [2:0] of the stored control byte are all 0. Otherwise it is ignored. The result is observed on the shadows after the next reset.
- R6: A programming write does not change any shadow output directly.
- R7: A bus write with `busAddr` equal to `TRIM_ADDR` (0xBA) updates `shadowTrim` on the next edge, but only when `loadDone` is 1 and `progMode` is 0. A bus write to any other address, in programming mode, or during loading changes no shadow.
- R8: A bus write to the trim shadow never alters the stored trim byte, so the next reset reloads the stored value.
- R9: If a programming write hits a register on the same edge that copies it, the shadow receives the previous stored value. The new value is copied at the following reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low; restores factory non-volatile values |
| rstN | input | 1 | System reset, active low; clears shadows and restarts the load sequence |
| progMode | input | 1 | Programming mode flag |
| nvWrEn | input | 1 | Programming write strobe |
| nvWrSel | input | 2 | Programming write target (0 control, 1 trim, 2 calibration, 3 port) |
| nvWrData | input | DATA_W | Programming write data |
| busWrEn | input | 1 | Software bus write strobe |
| busAddr | input | ADDR_W | Software bus write address |
| busWrData | input | DATA_W | Software bus write data |
| shadowCtl | output | DATA_W | Control shadow: security [2:0], feature enables [5:3], clock select [6] |
| shadowTrim | output | DATA_W | Oscillator trim shadow |
| shadowCal | output | DATA_W | Comparator/current calibration shadow |
| shadowPort | output | DATA_W | Port initial-state shadow |
| loadDone | output | 1 | Load sequence complete |

## Verification
Two functions can land on the same edge: the load sequence copying a register, and a programming write to that same register. The bench releases reset with programming mode held and issues a write to the trim byte just before the third edge, which is the edge that copies it. It then checks that the shadow shows the old trim value and that a second reset brings in the new one. Random stimulus also mixes bus writes and programming writes with loading. A bench model judges every cycle, with the copy taken from the stored value before the edge.

// File: rtl/shadow_loader_pkg.sv
package shadow_loader_pkg;
  localparam int NUM_REGS = 4;
  localparam int SEL_W    = $clog2(NUM_REGS);
  localparam int STEP_W   = $clog2(NUM_REGS + 1);
  localparam int SEC_W    = 3;

  localparam int IDX_CTL  = 0;
  localparam int IDX_TRIM = 1;
  localparam int IDX_CAL  = 2;
  localparam int IDX_PORT = 3;

  typedef struct packed {
    logic [NUM_REGS-1:0] loadSel;
    logic                nvWe;
    logic                trimWe;
  } shadow_stb_t;

  // Sequence slot in which register idx is copied: last register first, then 0,1,2...
  function automatic int loadSlot(int idx);
    return (idx == NUM_REGS - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/shadow_load_ctrl.sv
module shadow_load_ctrl
  import shadow_loader_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] TRIM_ADDR = 8'hBA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progMode,
  input  logic              nvWrEn,
  input  logic              secClear,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output shadow_stb_t       stb,
  output logic              loadDone
);
  logic [STEP_W-1:0]   stepQ;
  logic                doneQ;
  logic [NUM_REGS-1:0] loadSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepQ <= '0;
      doneQ <= 1'b0;
    end else if (!doneQ) begin
      stepQ <= stepQ + STEP_W'(1);
      if (stepQ == STEP_W'(NUM_REGS - 1)) doneQ <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign loadSel[g] = !doneQ && (stepQ == STEP_W'(loadSlot(g)));
  end

  always_comb begin
    stb.loadSel = loadSel;
    stb.nvWe    = nvWrEn && progMode && secClear;
    stb.trimWe  = busWrEn && (busAddr == TRIM_ADDR) && doneQ && !progMode;
  end

  assign loadDone = doneQ;
endmodule

// File: rtl/shadow_datapath.sv
module shadow_datapath
  import shadow_loader_pkg::*;
#(
  parameter int                DATA_W       = 8,
  parameter logic [DATA_W-1:0] FACTORY_TRIM = 8'h5A,
  parameter logic [DATA_W-1:0] FACTORY_CAL  = 8'h93,
  parameter logic [DATA_W-1:0] FACTORY_PORT = 8'h21
) (
  input  logic                             clk,
  input  logic                             porN,
  input  logic                             rstN,
  input  shadow_stb_t                      stb,
  input  logic [SEL_W-1:0]                 nvWrSel,
  input  logic [DATA_W-1:0]                nvWrData,
  input  logic [DATA_W-1:0]                busWrData,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  shadowQ,
  output logic                             secClear
);
  localparam logic [NUM_REGS-1:0][DATA_W-1:0] FACTORY =
    {FACTORY_PORT, FACTORY_CAL, FACTORY_TRIM, {DATA_W{1'b0}}};

  logic [DATA_W-1:0] nvAll [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
    logic [DATA_W-1:0] nvCell;
    logic [DATA_W-1:0] shCell;

    // Stored byte: survives system reset, cleared to factory value at power-on.
    always_ff @(posedge clk or negedge porN) begin
      if (!porN)                                    nvCell <= FACTORY[g];
      else if (stb.nvWe && nvWrSel == SEL_W'(g))    nvCell <= nvWrData;
    end

    if (g == IDX_TRIM) begin : g_trim
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                shCell <= '0;
        else if (stb.loadSel[g])  shCell <= nvCell;
        else if (stb.trimWe)      shCell <= busWrData;
      end
    end else begin : g_fixed
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                shCell <= '0;
        else if (stb.loadSel[g])  shCell <= nvCell;
      end
    end

    assign nvAll[g]   = nvCell;
    assign shadowQ[g] = shCell;
  end

  assign secClear = (nvAll[IDX_CTL][SEC_W-1:0] == '0);
endmodule

// File: rtl/init_shadow_loader.sv
module init_shadow_loader
  import shadow_loader_pkg::*;
#(
  parameter int                DATA_W       = 8,
  parameter int                ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] TRIM_ADDR    = 8'hBA,
  parameter logic [DATA_W-1:0] FACTORY_TRIM = 8'h5A,
  parameter logic [DATA_W-1:0] FACTORY_CAL  = 8'h93,
  parameter logic [DATA_W-1:0] FACTORY_PORT = 8'h21
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              progMode,
  input  logic              nvWrEn,
  input  logic [SEL_W-1:0]  nvWrSel,
  input  logic [DATA_W-1:0] nvWrData,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] shadowCtl,
  output logic [DATA_W-1:0] shadowTrim,
  output logic [DATA_W-1:0] shadowCal,
  output logic [DATA_W-1:0] shadowPort,
  output logic              loadDone
);
  shadow_stb_t                     stb;
  logic                            secClear;
  logic [NUM_REGS-1:0][DATA_W-1:0] shadowQ;

  shadow_load_ctrl #(
    .ADDR_W   (ADDR_W),
    .TRIM_ADDR(TRIM_ADDR)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .progMode(progMode),
    .nvWrEn  (nvWrEn),
    .secClear(secClear),
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .stb     (stb),
    .loadDone(loadDone)
  );

  shadow_datapath #(
    .DATA_W      (DATA_W),
    .FACTORY_TRIM(FACTORY_TRIM),
    .FACTORY_CAL (FACTORY_CAL),
    .FACTORY_PORT(FACTORY_PORT)
  ) u_dp (
    .clk      (clk),
    .porN     (porN),
    .rstN     (rstN),
    .stb      (stb),
    .nvWrSel  (nvWrSel),
    .nvWrData (nvWrData),
    .busWrData(busWrData),
    .shadowQ  (shadowQ),
    .secClear (secClear)
  );

  assign shadowCtl  = shadowQ[IDX_CTL];
  assign shadowTrim = shadowQ[IDX_TRIM];
  assign shadowCal  = shadowQ[IDX_CAL];
  assign shadowPort = shadowQ[IDX_PORT];
endmodule

// File: rtl/shadow_loader_checker.sv
module shadow_loader_checker #(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] TRIM_ADDR = 8'hBA
) (
  input logic              clk,
  input logic              porN,
  input logic              rstN,
  input logic              progMode,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] shadowCtl,
  input logic [DATA_W-1:0] shadowTrim,
  input logic [DATA_W-1:0] shadowCal,
  input logic [DATA_W-1:0] shadowPort,
  input logic              loadDone
);
  logic [2:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sinceRst <= '0;
    else if (sinceRst < 3'd4) sinceRst <= sinceRst + 3'd1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!porN)
    !rstN |-> (!loadDone && shadowCtl == '0 && shadowTrim == '0 && shadowCal == '0 && shadowPort == '0)); // R2

  AST_CTL_NOT_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < 3'd2) |-> (shadowCtl == '0)); // R3

  AST_TRIM_NOT_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < 3'd3) |-> (shadowTrim == '0)); // R3

  AST_CAL_NOT_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < 3'd4) |-> (shadowCal == '0)); // R3

  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    loadDone == (sinceRst == 3'd4)); // R4

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> loadDone); // R4

  AST_FIXED_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> ($stable(shadowCtl) && $stable(shadowCal) && $stable(shadowPort))); // R6

  AST_TRIM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (loadDone && busWrEn && busAddr == TRIM_ADDR && !progMode) |=> (shadowTrim == $past(busWrData))); // R7

  AST_TRIM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (loadDone && !(busWrEn && busAddr == TRIM_ADDR && !progMode)) |=> $stable(shadowTrim)); // R7
endmodule

bind init_shadow_loader shadow_loader_checker #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .TRIM_ADDR(TRIM_ADDR)
) u_chk (
  .clk       (clk),
  .porN      (porN),
  .rstN      (rstN),
  .progMode  (progMode),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .shadowCtl (shadowCtl),
  .shadowTrim(shadowTrim),
  .shadowCal (shadowCal),
  .shadowPort(shadowPort),
  .loadDone  (loadDone)
);

// File: tb/init_shadow_loader_bench.sv
module init_shadow_loader_bench;
  localparam logic [7:0] F_TRIM = 8'h5A;
  localparam logic [7:0] F_CAL  = 8'h93;
  localparam logic [7:0] F_PORT = 8'h21;
  localparam logic [7:0] A_TRIM = 8'hBA;

  logic       clk = 1'b0;
  logic       porN, rstN, progMode, nvWrEn, busWrEn;
  logic [1:0] nvWrSel;
  logic [7:0] nvWrData, busAddr, busWrData;
  logic [7:0] shadowCtl, shadowTrim, shadowCal, shadowPort;
  logic       loadDone;

  int nChecks = 0;
  int nErr    = 0;

  logic [7:0] mNv [4];
  logic [7:0] mSh [4];
  int         mStep;
  bit         mDone;

  always #5 clk = ~clk;

  init_shadow_loader #(
    .DATA_W(8), .ADDR_W(8), .TRIM_ADDR(A_TRIM),
    .FACTORY_TRIM(F_TRIM), .FACTORY_CAL(F_CAL), .FACTORY_PORT(F_PORT)
  ) u_init_shadow_loader (
    .clk(clk), .porN(porN), .rstN(rstN), .progMode(progMode),
    .nvWrEn(nvWrEn), .nvWrSel(nvWrSel), .nvWrData(nvWrData),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .shadowCtl(shadowCtl), .shadowTrim(shadowTrim), .shadowCal(shadowCal),
    .shadowPort(shadowPort), .loadDone(loadDone)
  );

  function automatic logic [7:0] factoryOf(int i);
    case (i)
      0: return 8'h00;
      1: return F_TRIM;
      2: return F_CAL;
      default: return F_PORT;
    endcase
  endfunction

  function automatic int slotReg(int step);
    return (step == 0) ? 3 : step - 1;
  endfunction

  task automatic modelPor();
    for (int i = 0; i < 4; i++) mNv[i] = factoryOf(i);
  endtask

  task automatic modelRst();
    for (int i = 0; i < 4; i++) mSh[i] = 8'h00;
    mStep = 0;
    mDone = 0;
  endtask

  task automatic modelEdge();
    if (rstN) begin
      if (!mDone) begin
        mSh[slotReg(mStep)] = mNv[slotReg(mStep)];
        mStep++;
        if (mStep == 4) mDone = 1;
      end else if (busWrEn && busAddr == A_TRIM && !progMode) begin
        mSh[1] = busWrData;
      end
    end
    if (porN && nvWrEn && progMode && mNv[0][2:0] == 3'b000) mNv[nvWrSel] = nvWrData;
  endtask

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    chk(tag, "shadowCtl",  shadowCtl,  mSh[0]);
    chk(tag, "shadowTrim", shadowTrim, mSh[1]);
    chk(tag, "shadowCal",  shadowCal,  mSh[2]);
    chk(tag, "shadowPort", shadowPort, mSh[3]);
    chk(tag, "loadDone",   {7'd0, loadDone}, {7'd0, mDone});
  endtask

  task automatic idle();
    progMode = 0; nvWrEn = 0; nvWrSel = 0; nvWrData = 0;
    busWrEn = 0; busAddr = 0; busWrData = 0;
  endtask

  task automatic nvWrite(logic [1:0] sel, logic [7:0] d);
    nvWrEn = 1; nvWrSel = sel; nvWrData = d;
  endtask

  task automatic busWrite(logic [7:0] a, logic [7:0] d);
    busWrEn = 1; busAddr = a; busWrData = d;
  endtask

  task automatic assertRst(string tag);
    rstN = 0;
    #1;
    modelRst();
    tick(tag);
    rstN = 1;
  endtask

  task automatic fullReload(string tag);
    assertRst("R2");
    repeat (5) tick(tag);
  endtask

  initial begin
    #(200000 * 10);
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    porN = 0; rstN = 0;
    idle();
    modelPor();
    modelRst();
    repeat (2) tick("R2");
    porN = 1;
    tick("R2");
    rstN = 1;
    // R3: sequential copy order, one per edge
    repeat (3) tick("R3");
    tick("R4");
    tick("R1");
    tick("R4");

    // R7: bus writes to trim, other address, in programming mode
    busWrite(A_TRIM, 8'hC3); tick("R7");
    busWrite(8'hBB, 8'h44);  tick("R7");
    progMode = 1; busWrite(A_TRIM, 8'h66); tick("R7");
    idle(); tick("R7");
    // R8: reset restores stored trim
    fullReload("R8");

    // R5: write ignored outside programming mode
    nvWrite(2'd2, 8'h77); tick("R5");
    // R6: accepted write does not touch shadow
    progMode = 1; nvWrite(2'd3, 8'h3C); tick("R6");
    idle(); tick("R6");
    fullReload("R5");

    // R9: programming write on the edge that copies the trim byte
    progMode = 1;
    assertRst("R2");
    tick("R9");
    tick("R9");
    nvWrite(2'd1, 8'hE1);
    tick("R9");
    idle();
    repeat (2) tick("R9");
    fullReload("R9");

    // R7: bus writes during loading are ignored, then take effect
    assertRst("R2");
    busWrite(A_TRIM, 8'h11);
    repeat (4) tick("R7");
    busWrite(A_TRIM, 8'h12);
    tick("R7");
    idle();
    tick("R7");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      progMode  = ($urandom % 4) == 0;
      nvWrEn    = ($urandom % 6) == 0;
      nvWrSel   = 2'($urandom);
      nvWrData  = 8'($urandom);
      if (nvWrSel == 2'd0) nvWrData = nvWrData & 8'hF8;
      busWrEn   = ($urandom % 2) == 0;
      busAddr   = (($urandom % 3) == 0) ? 8'($urandom) : A_TRIM;
      busWrData = 8'($urandom);
      if (($urandom % 150) == 0) assertRst("R2");
      else tick("R7");
    end
    idle();
    fullReload("R5");

    // R5: security bits lock further programming writes
    progMode = 1; nvWrite(2'd0, 8'h05); tick("R5");
    nvWrite(2'd3, 8'hAA); tick("R5");
    idle();
    fullReload("R5");

    // R1: power-on restores factory values
    porN = 0;
    #1;
    modelPor();
    tick("R1");
    porN = 1;
    fullReload("R1");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule